// File: doc/BRIEF.md
# Eye-Monitor Histogram Scan Controller

This block runs a two-dimensional eye scan for a receiver that has a single monitor comparator beside its data slicers. It steps a phase code across one unit interval and, at each phase, steps a 5-bit reference-voltage code from the bottom of its range to the top. At each grid point it counts monitor decisions until a fixed number of qualifying samples has arrived. A sample qualifies only when the current decided data symbol fits the half of the voltage range being measured and, if the pattern filter is on, when the recent symbol history matches a chosen pattern. The result is a cumulative histogram for the column.

When a column of voltage points is complete, the block differentiates the stored counts into a histogram. Each output is the magnitude of the difference between a point and its neighbour, and the results leave through a streaming output one point per cycle. The phase interpolator and the comparator sit outside the block and follow `phase_code` and `vref_code`. A system controller pulses `start` and collects the histogram stream until `done` goes high.

Phase code 0 stands for half a unit interval before the data sampling instant. Code 2^(PH_W-1) is the sampling instant, and the all-ones code is the last step before the next interval. The sampling instant is that of the data clock at 180 degrees.

Top module: `eye_scan_ctrl`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done` and `hist_vld` are 0 and `phase_code` and `vref_code` are 0.
- R2: A scan starts from phase 0 and voltage 0. The voltage code rises by one per completed point up to all-ones, then the phase code rises by one and the voltage code returns to 0. Histogram values come out ordered by phase, then by ascending voltage, with `hist_phase`/`hist_vref` naming each point. A scan emits exactly 2^PH_W × 2^V_W values.
- R3: When `vref_code[V_W-1]` is 0 (lower half), a sample qualifies only if `smp_vld`=1 and `sym`=0, and it adds one to the point's count when `mon`=1.
- R4: When `vref_code[V_W-1]` is 1 (upper half), a sample qualifies only if `smp_vld`=1 and `sym`=1, and it adds one to the point's count when `mon`=0.
- R5: A point closes on exactly its NS-th qualifying sample, and the codes move on at that clock edge. Without qualifying samples the codes hold.
- R6: A point's count saturates at 2^CNT_W-1 instead of wrapping.
- R7: In the lower half, the output for voltage v is |c[v] − c[v+1]|. For the top point of the lower half the neighbour is taken as 0.
- R8: In the upper half, the output for voltage v is |c[v] − c[v−1]|. For the bottom point of the upper half the neighbour is taken as 0.
- R9: The history is {symbol two valid samples back, symbol one back, current `sym`}, and it shifts on every `smp_vld`. With `filt_en`=1, an upper-half sample qualifies only if the history equals `filt_pat`, and a lower-half sample only if it equals ~`filt_pat`. With `filt_en`=0 the history is not used.
- R10: `done` rises together with the last histogram value of the last phase, and `busy` falls at the same time. `done` stays high until the next `start` clears it.
- R11: A `start` pulse during a scan has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan when idle |
| filt_en | input | 1 | Enable the three-bit pattern filter |
| filt_pat | input | 3 | Pattern for the upper half; its complement applies to the lower half |
| smp_vld | input | 1 | A monitor sample and data symbol are present |
| sym | input | 1 | Current decided data symbol |
| mon | input | 1 | Monitor comparator output |
| phase_code | output | PH_W | Monitor clock phase step |
| vref_code | output | V_W | Monitor reference voltage code |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished |
| hist_vld | output | 1 | Histogram value valid |
| hist_phase | output | PH_W | Phase of the histogram value |
| hist_vref | output | V_W | Voltage of the histogram value |
| hist_val | output | CNT_W | Histogram magnitude |

## Verification
A wrong sample gate or a wrong history register does not stop the scan, but it changes the values stored for the affected points. It therefore appears as wrong `hist_val` outputs when that column is differentiated, at most 2^V_W+1 cycles after the column's last point. A point counter that closes early or late shows up at once as codes that advance after the wrong number of qualifying samples, or as a stalled scan. A wrong sweep or done state shows up directly on the codes and in the order of the histogram stream.

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl #(
  parameter int PH_W  = 5,
  parameter int V_W   = 5,
  parameter int NS    = 20,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             filt_en,
  input  logic [2:0]       filt_pat,
  input  logic             smp_vld,
  input  logic             sym,
  input  logic             mon,
  output logic [PH_W-1:0]  phase_code,
  output logic [V_W-1:0]   vref_code,
  output logic             busy,
  output logic             done,
  output logic             hist_vld,
  output logic [PH_W-1:0]  hist_phase,
  output logic [V_W-1:0]   hist_vref,
  output logic [CNT_W-1:0] hist_val
);

  localparam int VN   = 1 << V_W;
  localparam int HALF = VN / 2;
  localparam int QW   = $clog2(NS + 1);
  localparam logic [CNT_W-1:0] CMAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_CNT, S_DIFF} st_t;

  st_t              st;
  logic [1:0]       hq;
  logic [QW-1:0]    qcnt;
  logic [CNT_W-1:0] acc;
  logic [V_W-1:0]   dv;
  logic [CNT_W-1:0] mem [VN];

  logic             upper, pat_ok, qual, hit, last_smp;
  logic [CNT_W-1:0] acc_nxt, cur, nb, diff;

  assign upper    = vref_code[V_W-1];
  assign pat_ok   = !filt_en || ({hq, sym} == (upper ? filt_pat : ~filt_pat));
  assign qual     = (st == S_CNT) && smp_vld && (sym == upper) && pat_ok;
  assign hit      = upper ? !mon : mon;
  assign acc_nxt  = (hit && acc != CMAX) ? acc + 1'b1 : acc;
  assign last_smp = qcnt == QW'(NS - 1);
  assign busy     = st != S_IDLE;

  assign cur = mem[dv];
  always_comb begin
    if (dv[V_W-1])
      nb = (dv == V_W'(HALF)) ? '0 : mem[dv - 1'b1];
    else
      nb = (dv == V_W'(HALF - 1)) ? '0 : mem[dv + 1'b1];
  end
  assign diff = (cur >= nb) ? cur - nb : nb - cur;

  always_ff @(posedge clk)
    if (qual && last_smp) mem[vref_code] <= acc_nxt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      hq         <= '0;
      qcnt       <= '0;
      acc        <= '0;
      dv         <= '0;
      phase_code <= '0;
      vref_code  <= '0;
      done       <= 1'b0;
      hist_vld   <= 1'b0;
      hist_phase <= '0;
      hist_vref  <= '0;
      hist_val   <= '0;
    end else begin
      hist_vld <= 1'b0;
      if (smp_vld) hq <= {hq[0], sym};
      case (st)
        S_IDLE: if (start) begin
          st         <= S_CNT;
          phase_code <= '0;
          vref_code  <= '0;
          acc        <= '0;
          qcnt       <= '0;
          done       <= 1'b0;
        end
        S_CNT: if (qual) begin
          if (last_smp) begin
            acc  <= '0;
            qcnt <= '0;
            if (vref_code == '1) begin
              st <= S_DIFF;
              dv <= '0;
            end else begin
              vref_code <= vref_code + 1'b1;
            end
          end else begin
            acc  <= acc_nxt;
            qcnt <= qcnt + 1'b1;
          end
        end
        S_DIFF: begin
          hist_vld   <= 1'b1;
          hist_phase <= phase_code;
          hist_vref  <= dv;
          hist_val   <= diff;
          dv         <= dv + 1'b1;
          if (dv == '1) begin
            if (phase_code == '1) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              phase_code <= phase_code + 1'b1;
              vref_code  <= '0;
              st         <= S_CNT;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/eye_scan_ctrl_chk.sv
module eye_scan_ctrl_chk #(
  parameter int PH_W = 5,
  parameter int V_W  = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            done,
  input logic            hist_vld,
  input logic [PH_W-1:0] hist_phase,
  input logic [V_W-1:0]  hist_vref,
  input logic [PH_W-1:0] phase_code,
  input logic [V_W-1:0]  vref_code
);

  // R2
  vref_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vref_code != $past(vref_code)) |-> (vref_code == $past(vref_code) + 1'b1) || (vref_code == '0));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_code != $past(phase_code)) |-> (vref_code == '0));

  // R11
  phase_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (phase_code >= $past(phase_code)));

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10
  done_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (hist_vld && hist_phase == '1 && hist_vref == '1));

endmodule

bind eye_scan_ctrl eye_scan_ctrl_chk #(.PH_W(PH_W), .V_W(V_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .hist_vld(hist_vld),
  .hist_phase(hist_phase), .hist_vref(hist_vref),
  .phase_code(phase_code), .vref_code(vref_code)
);

// File: tb/test_eye_scan_ctrl.sv
module test_eye_scan_ctrl;
  localparam int PH_W = 2, V_W = 5, NS = 20, CNT_W = 4;
  localparam int NPH = 1 << PH_W, NV = 1 << V_W, HALF = NV / 2;
  localparam int CMAX = (1 << CNT_W) - 1;
  // {filt_en, filt_pat[2:0], seed[4:0], mid_start}
  localparam logic [9:0] CFG [4] = '{
    {1'b0, 3'b000, 5'd0,  1'b0},
    {1'b0, 3'b000, 5'd7,  1'b1},
    {1'b1, 3'b111, 5'd3,  1'b0},
    {1'b1, 3'b101, 5'd11, 1'b0}
  };

  logic clk = 0, rst_n = 0, start = 0, filt_en = 0, smp_vld = 0, sym = 0, mon = 0;
  logic [2:0] filt_pat = '0;
  logic [PH_W-1:0] phase_code, hist_phase;
  logic [V_W-1:0] vref_code, hist_vref;
  logic busy, done, hist_vld;
  logic [CNT_W-1:0] hist_val;

  int n_chk = 0, n_fail = 0, cyc_all = 0;
  bit wd = 0;
  logic [1:0] bh = '0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;
  always @(posedge clk) begin
    cyc_all <= cyc_all + 1;
    if (cyc_all == 190000) wd <= 1'b1;
  end

  eye_scan_ctrl #(.PH_W(PH_W), .V_W(V_W), .NS(NS), .CNT_W(CNT_W)) i_eye_scan_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .filt_en(filt_en), .filt_pat(filt_pat),
    .smp_vld(smp_vld), .sym(sym), .mon(mon), .phase_code(phase_code), .vref_code(vref_code),
    .busy(busy), .done(done), .hist_vld(hist_vld), .hist_phase(hist_phase),
    .hist_vref(hist_vref), .hist_val(hist_val));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int cum(input int p, input int v, input int seed);
    int h = (p * 5 + v * 3 + seed) % 21;
    return (h > CMAX) ? CMAX : h;
  endfunction

  function automatic int exp_hist(input int p, input int v, input int seed);
    int nb, c;
    c = cum(p, v, seed);
    if (v < HALF) nb = (v == HALF - 1) ? 0 : cum(p, v + 1, seed);
    else          nb = (v == HALF) ? 0 : cum(p, v - 1, seed);
    return (c >= nb) ? c - nb : nb - c;
  endfunction

  task automatic check_idle(input string req);
    chk(!busy && !done && !hist_vld, req, "busy/done/hist_vld", {busy, done, hist_vld}, 0);
    chk(phase_code == 0 && vref_code == 0, req, "codes", {phase_code, vref_code}, 0);
  endtask

  task automatic run_scan(input bit fen, input logic [2:0] pat, input int seed, input bit mid, input string tag);
    int k = 0, ep = 0, ev = 0, cyc = 0, h, nout = 0;
    bit fin = 0, mid_done = 0, up, s, q, hv;
    logic [PH_W-1:0] lp;
    logic [V_W-1:0] lv;
    @(negedge clk);
    filt_en = fen; filt_pat = pat; start = 1; smp_vld = 0;
    @(negedge clk);
    start = 0;
    lp = phase_code; lv = vref_code;
    while (!fin && !wd) begin
      if (hist_vld) begin
        chk(hist_phase == ep[PH_W-1:0] && hist_vref == ev[V_W-1:0], "R2", "hist order",
            {hist_phase, hist_vref}, (ep << V_W) | ev);
        chk(hist_val == exp_hist(ep, ev, seed), (ev < HALF) ? "R7" : "R8", tag,
            hist_val, exp_hist(ep, ev, seed));
        nout++;
        if (ep == NPH - 1 && ev == NV - 1) begin
          chk(done && !busy, "R10", "done with last value", {done, busy}, 2);
          fin = 1;
        end
        ev++;
        if (ev == NV) begin ev = 0; ep++; end
      end
      if (phase_code != lp || vref_code != lv) begin
        chk(k == NS, "R5", "samples per point", k, NS);
        k = 0; lp = phase_code; lv = vref_code;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      up = lv[V_W-1];
      hv = up ? 1'b0 : 1'b1;
      start = (mid && !mid_done && phase_code == 1 && vref_code == 5);
      if (start) mid_done = 1;
      if (k >= NS || (cyc % 5) == 0) begin
        smp_vld = 0; sym = up; mon = hv;
      end else begin
        s = lfsr[0];
        q = (s == up) && (!fen || ({bh, s} == (up ? pat : ~pat)));
        smp_vld = 1; sym = s;
        if (q) begin
          h = (lp * 5 + lv * 3 + seed) % 21;
          mon = (k < h) ? hv : ~hv;
          k++;
        end else begin
          mon = hv;
        end
        bh = {bh[0], s};
      end
      cyc++;
      @(negedge clk);
    end
    smp_vld = 0; start = 0;
    chk(nout == NPH * NV, "R2", "values per scan", nout, NPH * NV);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    rst_n = 1;
    repeat (2) @(negedge clk);
    check_idle("R1");

    for (int i = 0; i < 4; i++) begin
      string tag;
      tag = CFG[i][9] ? "R9 filtered" : (CFG[i][0] ? "R11 restart ignored" : "R3 R4 R6 gated");
      run_scan(CFG[i][9], CFG[i][8:6], int'(CFG[i][5:1]), CFG[i][0], tag);
    end

    repeat (5) @(negedge clk);
    chk(done && !busy, "R10", "done held", {done, busy}, 2);

    start = 1; smp_vld = 0;
    @(negedge clk);
    start = 0;
    chk(busy && !done, "R10", "start clears done", {busy, done}, 2);
    repeat (20) @(negedge clk);
    chk(phase_code == 0 && vref_code == 0, "R5", "no advance without samples",
        {phase_code, vref_code}, 0);
    rst_n = 0;
    @(negedge clk);
    check_idle("R1");
    rst_n = 1; bh = '0;
    @(negedge clk);
    check_idle("R1");

    if (wd) chk(0, "watchdog", "run expired", cyc_all, 190000);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule